// File: doc/BRIEF.md
# Slot-Scheduled Shared Memory Port for Trie Lookup Engines

This block places a group of up to eight trie lookup engines and one control-processor port onto a single external SRAM that accepts one access per clock. A free-running 3-bit slot counter splits time into an eight-cycle frame. Slot number s belongs to engine s, which matches an engine that needs one memory access every eight cycles. The number of engines is chosen at build time. With eight engines the memory bandwidth is fully used, and with fewer engines the spare slots remain available.

The control processor shares the same SRAM for route-table updates while lookups continue. It receives any slot whose owner is absent or is not requesting. If it has waited through eight straight cycles of busy slots, the next slot is taken for it. New lookup keys are handed out round-robin to free engines. Each accepted key carries a sequence tag. An engine keeps its result until that result's turn comes, so results always leave in the order the keys arrived. Read data from the SRAM is steered to whichever requester owned the slot in which the read was issued.

Each engine has a three-state seat: `SLOT_IDLE`, `SLOT_BUSY` and `SLOT_HOLD`. A seat goes from idle to busy on dispatch, from busy to hold when the engine reports done, and from hold back to idle in the cycle its result is emitted. The control-port arbiter also has three states: `ARB_CALM`, `ARB_WAIT` and `ARB_DUE`. It goes from calm to wait when a control request is refused, from wait to due after the eighth refused cycle in a row, and back to calm once the request is granted or withdrawn.

Top module: `trie_mem_sched`

## Requirements
- R1: The slot counter is 0 in the first cycle after reset and advances by one each cycle, modulo 8. A memory request from engine i is granted only in a cycle whose slot equals i. At most one requester (an engine or the control port) is granted in any cycle.
- R2: In a cycle whose slot belongs to an engine that is not built or not requesting, a pending control request is granted in that same cycle.
- R3: If a control request stays pending and is refused for 8 consecutive cycles, it is granted in the 9th cycle, even if the engine that owns that slot is requesting.
- R4: An accepted key goes to the first free engine found by scanning upward, with wrap-around, from the engine after the one that received the previous key. After reset the scan starts at engine 0. `req_ready` is 0 exactly when no engine is free, and no engine is started while it is 0.
- R5: Results appear on `res_data` with `res_valid` high for one cycle each, in the order the keys were accepted, whatever order the engines finish in. An engine stays occupied until its own result has been emitted.
- R6: An engine's `eng_rd_valid` bit is high RD_LAT cycles (default 1) after a read was granted to that engine, and at no other time. `cpu_rvalid` is high RD_LAT cycles after a control read was granted.
- R7: In a control grant cycle, `sram_en` is 1, `sram_we` equals `cpu_we`, and `sram_addr`/`sram_wdata` carry `cpu_addr`/`cpu_wdata`. A later control read of that address returns the written word on `cpu_rdata`.
- R8: While reset is held and in the first cycle after it is released, `req_ready` is 1, `res_valid` is 0, `sram_en` is 0 and no grant or start is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lookup key is offered |
| req_key | input | KEY_W | Lookup key |
| req_ready | output | 1 | At least one engine is free |
| eng_start | output | NUM_ENG | One-cycle start pulse, one bit per engine |
| eng_key | output | KEY_W | Key delivered with the start pulse |
| eng_mem_req | input | NUM_ENG | Engine wants an SRAM read |
| eng_mem_addr | input | NUM_ENG*ADDR_W | Read address per engine, engine i at bits i*ADDR_W |
| eng_grant | output | NUM_ENG | Engine's read is issued this cycle |
| eng_rd_valid | output | NUM_ENG | Returned read data belongs to this engine |
| eng_rd_data | output | DATA_W | Returned read data |
| eng_done | input | NUM_ENG | Engine finished its lookup (one-cycle pulse) |
| eng_result | input | NUM_ENG*RES_W | Result per engine, engine i at bits i*RES_W |
| cpu_valid | input | 1 | Control access pending, held until granted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Control access address |
| cpu_wdata | input | DATA_W | Control write data |
| cpu_grant | output | 1 | Control access issued this cycle |
| cpu_rvalid | output | 1 | Control read data valid |
| cpu_rdata | output | DATA_W | Control read data |
| sram_en | output | 1 | SRAM access this cycle |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data, RD_LAT cycles after the access |
| res_valid | output | 1 | An in-order result is presented |
| res_data | output | RES_W | Result value |

## Verification
Several rules are checked by assertions on every clock cycle: the slot counter steps by one each cycle, an engine is granted only in its own slot, at most one owner is granted per cycle, an idle slot goes at once to a waiting control access, the ninth cycle of control waiting always brings a grant, no start is issued while ready is low, and control read-valid follows a control read. The bench scenarios show the rest. They check that results leave in request order when engines finish out of order, that round-robin dispatch runs from engine 0 upward, that read data reaches the correct engine (checked through correct lookup sums), that a forced control grant comes after exactly eight refused cycles with all eight engines loading memory, and that control writes can be read back.

// File: rtl/tms_pkg.sv
package tms_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_BUSY,
        SLOT_HOLD
    } seat_state_e;

    typedef enum logic [1:0] {
        ARB_CALM,
        ARB_WAIT,
        ARB_DUE
    } arb_state_e;

endpackage

// File: rtl/tms_engine_seat.sv
module tms_engine_seat
    import tms_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             release_i,
    output logic             free_o,
    output logic             hold_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [RES_W-1:0] result_o
);

    seat_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (start_i)   state_d = SLOT_BUSY;
            SLOT_BUSY: if (done_i)    state_d = SLOT_HOLD;
            SLOT_HOLD: if (release_i) state_d = SLOT_IDLE;
            default:                  state_d = SLOT_IDLE;
        endcase
    end

    // captured tag and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o    <= '0;
            result_o <= '0;
        end else begin
            if (start_i && state_q == SLOT_IDLE) tag_o    <= tag_i;
            if (done_i  && state_q == SLOT_BUSY) result_o <= result_i;
        end
    end

    // outputs
    always_comb begin
        free_o = (state_q == SLOT_IDLE);
        hold_o = (state_q == SLOT_HOLD);
    end

endmodule

// File: rtl/tms_slot_arb.sv
module tms_slot_arb
    import tms_pkg::*;
#(
    parameter int NUM_ENG = 8,
    parameter int PERIOD  = 8,
    parameter int SLOT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENG-1:0] eng_req_i,
    input  logic               cpu_req_i,
    output logic [SLOT_W-1:0]  slot_o,
    output logic [NUM_ENG-1:0] eng_grant_o,
    output logic               cpu_grant_o
);

    localparam int CNT_W = $clog2(PERIOD);

    arb_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [SLOT_W-1:0] slot_q;
    logic [PERIOD-1:0] slot_req;
    logic              owner_busy;
    logic              due;

    // map every slot to its engine's request; absent engines never request
    for (genvar s = 0; s < PERIOD; s++) begin : g_slot_req
        if (s < NUM_ENG) begin : g_present
            assign slot_req[s] = eng_req_i[s];
        end else begin : g_absent
            assign slot_req[s] = 1'b0;
        end
    end

    always_comb begin
        owner_busy  = slot_req[slot_q];
        due         = (st_q == ARB_DUE);
        cpu_grant_o = cpu_req_i && (!owner_busy || due);
        slot_o      = slot_q;
    end

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_grant
        assign eng_grant_o[i] = (slot_q == SLOT_W'(i)) && eng_req_i[i] && !due;
    end

    // state register and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ARB_CALM;
            cnt_q  <= '0;
            slot_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            slot_q <= slot_q + 1'b1;
        end
    end

    // waiting-control transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ARB_CALM: begin
                if (cpu_req_i && !cpu_grant_o) begin
                    st_d  = ARB_WAIT;
                    cnt_d = CNT_W'(1);
                end
            end
            ARB_WAIT: begin
                if (!cpu_req_i || cpu_grant_o) begin
                    st_d  = ARB_CALM;
                    cnt_d = '0;
                end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
                    st_d = ARB_DUE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ARB_DUE: begin
                st_d  = ARB_CALM;
                cnt_d = '0;
            end
            default: begin
                st_d  = ARB_CALM;
                cnt_d = '0;
            end
        endcase
    end

endmodule

// File: rtl/tms_rd_route.sv
module tms_rd_route #(
    parameter int NUM_ENG = 8,
    parameter int RD_LAT  = 1,
    parameter int SLOT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid_i,
    input  logic               issue_cpu_i,
    input  logic [SLOT_W-1:0]  issue_slot_i,
    output logic [NUM_ENG-1:0] eng_rd_valid_o,
    output logic               cpu_rvalid_o
);

    logic [RD_LAT-1:0] v_q;
    logic [RD_LAT-1:0] c_q;
    logic [SLOT_W-1:0] sl_q [RD_LAT];

    // delayed copy of the slot owner, aligned with SRAM read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            c_q <= '0;
            for (int s = 0; s < RD_LAT; s++) sl_q[s] <= '0;
        end else begin
            v_q[0]  <= issue_valid_i;
            c_q[0]  <= issue_cpu_i;
            sl_q[0] <= issue_slot_i;
            for (int s = 1; s < RD_LAT; s++) begin
                v_q[s]  <= v_q[s-1];
                c_q[s]  <= c_q[s-1];
                sl_q[s] <= sl_q[s-1];
            end
        end
    end

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_route
        assign eng_rd_valid_o[i] = v_q[RD_LAT-1] && !c_q[RD_LAT-1]
                                   && (sl_q[RD_LAT-1] == SLOT_W'(i));
    end

    assign cpu_rvalid_o = v_q[RD_LAT-1] && c_q[RD_LAT-1];

endmodule

// File: rtl/trie_mem_sched.sv
module trie_mem_sched
    import tms_pkg::*;
#(
    parameter int NUM_ENG = 8,
    parameter int KEY_W   = 32,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int RES_W   = 32,
    parameter int RD_LAT  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [KEY_W-1:0]          req_key,
    output logic                      req_ready,
    output logic [NUM_ENG-1:0]        eng_start,
    output logic [KEY_W-1:0]          eng_key,
    input  logic [NUM_ENG-1:0]        eng_mem_req,
    input  logic [NUM_ENG*ADDR_W-1:0] eng_mem_addr,
    output logic [NUM_ENG-1:0]        eng_grant,
    output logic [NUM_ENG-1:0]        eng_rd_valid,
    output logic [DATA_W-1:0]         eng_rd_data,
    input  logic [NUM_ENG-1:0]        eng_done,
    input  logic [NUM_ENG*RES_W-1:0]  eng_result,
    input  logic                      cpu_valid,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    output logic                      cpu_grant,
    output logic                      cpu_rvalid,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      sram_en,
    output logic                      sram_we,
    output logic [ADDR_W-1:0]         sram_addr,
    output logic [DATA_W-1:0]         sram_wdata,
    input  logic [DATA_W-1:0]         sram_rdata,
    output logic                      res_valid,
    output logic [RES_W-1:0]          res_data
);

    localparam int PERIOD = 8;
    localparam int SLOT_W = 3;
    localparam int ENG_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;
    localparam int TAG_W  = ENG_W + 1;

    logic [NUM_ENG-1:0] seat_free, seat_hold, hit;
    logic [TAG_W-1:0]   seat_tag [NUM_ENG];
    logic [RES_W-1:0]   seat_res [NUM_ENG];
    logic [ENG_W-1:0]   rr_q, pick;
    logic               pick_ok, fire;
    logic [TAG_W-1:0]   in_seq_q, out_seq_q;
    logic [SLOT_W-1:0]  slot;
    logic [ADDR_W-1:0]  eng_addr_sel;
    int                 idx;

    // round-robin search for a free engine
    always_comb begin
        pick_ok = 1'b0;
        pick    = '0;
        idx     = 0;
        for (int k = 0; k < NUM_ENG; k++) begin
            idx = int'(rr_q) + k;
            if (idx >= NUM_ENG) idx = idx - NUM_ENG;
            if (!pick_ok && seat_free[idx]) begin
                pick_ok = 1'b1;
                pick    = ENG_W'(idx);
            end
        end
    end

    assign req_ready = pick_ok;
    assign fire      = req_valid && pick_ok;
    assign eng_key   = req_key;

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_seat
        assign eng_start[i] = fire && (pick == ENG_W'(i));
        assign hit[i]       = seat_hold[i] && (seat_tag[i] == out_seq_q);

        tms_engine_seat #(
            .TAG_W (TAG_W),
            .RES_W (RES_W)
        ) u_seat (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (eng_start[i]),
            .tag_i     (in_seq_q),
            .done_i    (eng_done[i]),
            .result_i  (eng_result[i*RES_W +: RES_W]),
            .release_i (hit[i]),
            .free_o    (seat_free[i]),
            .hold_o    (seat_hold[i]),
            .tag_o     (seat_tag[i]),
            .result_o  (seat_res[i])
        );
    end

    // dispatch pointer and sequence tags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q      <= '0;
            in_seq_q  <= '0;
            out_seq_q <= '0;
        end else begin
            if (fire) begin
                in_seq_q <= in_seq_q + 1'b1;
                if (int'(pick) == NUM_ENG - 1) rr_q <= '0;
                else                           rr_q <= pick + 1'b1;
            end
            if (res_valid) out_seq_q <= out_seq_q + 1'b1;
        end
    end

    // in-order result selection
    always_comb begin
        res_valid = |hit;
        res_data  = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (hit[i]) res_data = res_data | seat_res[i];
        end
    end

    tms_slot_arb #(
        .NUM_ENG (NUM_ENG),
        .PERIOD  (PERIOD),
        .SLOT_W  (SLOT_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .eng_req_i   (eng_mem_req),
        .cpu_req_i   (cpu_valid),
        .slot_o      (slot),
        .eng_grant_o (eng_grant),
        .cpu_grant_o (cpu_grant)
    );

    // memory port multiplexer
    always_comb begin
        eng_addr_sel = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (eng_grant[i]) eng_addr_sel = eng_addr_sel | eng_mem_addr[i*ADDR_W +: ADDR_W];
        end
        sram_en    = cpu_grant || (|eng_grant);
        sram_we    = cpu_grant && cpu_we;
        sram_addr  = cpu_grant ? cpu_addr : eng_addr_sel;
        sram_wdata = cpu_wdata;
    end

    tms_rd_route #(
        .NUM_ENG (NUM_ENG),
        .RD_LAT  (RD_LAT),
        .SLOT_W  (SLOT_W)
    ) u_route (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_valid_i  (sram_en && !sram_we),
        .issue_cpu_i    (cpu_grant),
        .issue_slot_i   (slot),
        .eng_rd_valid_o (eng_rd_valid),
        .cpu_rvalid_o   (cpu_rvalid)
    );

    assign eng_rd_data = sram_rdata;
    assign cpu_rdata   = sram_rdata;

endmodule

// File: rtl/trie_mem_sched_chk.sv
module trie_mem_sched_chk #(
    parameter int NUM_ENG = 8,
    parameter int RD_LAT  = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         slot,
    input logic [NUM_ENG-1:0] eng_mem_req,
    input logic [NUM_ENG-1:0] eng_grant,
    input logic [NUM_ENG-1:0] eng_start,
    input logic               req_ready,
    input logic               cpu_valid,
    input logic               cpu_we,
    input logic               cpu_grant,
    input logic               cpu_rvalid
);

    logic       owner_busy;
    logic [3:0] refused;

    always_comb begin
        owner_busy = 1'b0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (slot == 3'(i) && eng_mem_req[i]) owner_busy = 1'b1;
        end
    end

    // independent count of consecutive refused control cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                       refused <= '0;
        else if (cpu_valid && !cpu_grant) refused <= refused + 1'b1;
        else                              refused <= '0;
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (slot == $past(slot) + 3'd1)); // R1

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_grant, cpu_grant})); // R1

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_own
        AST_GRANT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            eng_grant[i] |-> (slot == 3'(i))); // R1
    end

    AST_IDLE_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !owner_busy) |-> cpu_grant); // R2

    AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && refused == 4'd8) |-> cpu_grant); // R3

    AST_NO_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (eng_start == '0)); // R4

    AST_CPU_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(cpu_grant && !cpu_we, RD_LAT)); // R6

endmodule

bind trie_mem_sched trie_mem_sched_chk #(
    .NUM_ENG (NUM_ENG),
    .RD_LAT  (RD_LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot        (slot),
    .eng_mem_req (eng_mem_req),
    .eng_grant   (eng_grant),
    .eng_start   (eng_start),
    .req_ready   (req_ready),
    .cpu_valid   (cpu_valid),
    .cpu_we      (cpu_we),
    .cpu_grant   (cpu_grant),
    .cpu_rvalid  (cpu_rvalid)
);

// File: tb/trie_mem_sched_bench.sv
module trie_mem_sched_bench;

    localparam int NE = 8;
    localparam int KW = 32;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int RW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              req_valid;
    logic [KW-1:0]     req_key;
    logic              req_ready;
    logic [NE-1:0]     eng_start;
    logic [KW-1:0]     eng_key;
    logic [NE-1:0]     eng_mem_req;
    logic [NE*AW-1:0]  eng_mem_addr;
    logic [NE-1:0]     eng_grant;
    logic [NE-1:0]     eng_rd_valid;
    logic [DW-1:0]     eng_rd_data;
    logic [NE-1:0]     eng_done;
    logic [NE*RW-1:0]  eng_result;
    logic              cpu_valid;
    logic              cpu_we;
    logic [AW-1:0]     cpu_addr;
    logic [DW-1:0]     cpu_wdata;
    logic              cpu_grant;
    logic              cpu_rvalid;
    logic [DW-1:0]     cpu_rdata;
    logic              sram_en;
    logic              sram_we;
    logic [AW-1:0]     sram_addr;
    logic [DW-1:0]     sram_wdata;
    logic [DW-1:0]     sram_rdata;
    logic              res_valid;
    logic [RW-1:0]     res_data;

    trie_mem_sched #(
        .NUM_ENG (NE), .KEY_W (KW), .ADDR_W (AW),
        .DATA_W (DW), .RES_W (RW), .RD_LAT (1)
    ) u_trie_mem_sched (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_key (req_key), .req_ready (req_ready),
        .eng_start (eng_start), .eng_key (eng_key),
        .eng_mem_req (eng_mem_req), .eng_mem_addr (eng_mem_addr),
        .eng_grant (eng_grant), .eng_rd_valid (eng_rd_valid),
        .eng_rd_data (eng_rd_data), .eng_done (eng_done),
        .eng_result (eng_result),
        .cpu_valid (cpu_valid), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
        .cpu_wdata (cpu_wdata), .cpu_grant (cpu_grant),
        .cpu_rvalid (cpu_rvalid), .cpu_rdata (cpu_rdata),
        .sram_en (sram_en), .sram_we (sram_we), .sram_addr (sram_addr),
        .sram_wdata (sram_wdata), .sram_rdata (sram_rdata),
        .res_valid (res_valid), .res_data (res_data)
    );

    int cyc;          // rising edges since reset release = slot count
    int rd_n = 2;     // reads each engine model performs per lookup
    int ic = 0, ifl = 0;   // checks/failures from the main sequence
    int mc = 0, mfl = 0;   // checks/failures from the monitor
    int pushed = 0, popped = 0;
    logic [RW-1:0] exp_arr [256];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // SRAM model, one-cycle read latency, word a holds a*7+3 after reset
    logic [DW-1:0] mem [1024];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 1024; a++) mem[a] <= DW'(a * 7 + 3);
        end else if (sram_en) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata     <= mem[sram_addr];
        end
    end

    // engine models: rd_n reads from key, key+1, ... then a key-dependent delay
    for (genvar gi = 0; gi < NE; gi++) begin : g_eng
        logic          busy, done_r;
        logic [AW-1:0] base;
        int            issued, got, dly;
        logic [RW-1:0] acc;

        assign eng_mem_req[gi]           = busy && (issued < rd_n);
        assign eng_mem_addr[gi*AW +: AW] = base + AW'(issued);
        assign eng_done[gi]              = done_r;
        assign eng_result[gi*RW +: RW]   = acc;

        always @(posedge clk) begin
            if (!rst_n) begin
                busy <= 1'b0; done_r <= 1'b0; issued <= 0; got <= 0;
                acc <= '0; dly <= 0; base <= '0;
            end else begin
                done_r <= 1'b0;
                if (eng_start[gi]) begin
                    busy   <= 1'b1;
                    base   <= eng_key[AW-1:0];
                    issued <= 0;
                    got    <= 0;
                    acc    <= '0;
                    dly    <= int'(eng_key[1:0]) * 6;
                end else if (busy) begin
                    if (eng_grant[gi]) issued <= issued + 1;
                    if (eng_rd_valid[gi]) begin
                        acc <= acc + eng_rd_data;
                        got <= got + 1;
                    end else if (got == rd_n) begin
                        if (dly == 0) begin
                            busy   <= 1'b0;
                            done_r <= 1'b1;
                        end else begin
                            dly <= dly - 1;
                        end
                    end
                end
            end
        end
    end

    function automatic logic [RW-1:0] lookup_sum(input logic [KW-1:0] k, input int n);
        logic [RW-1:0] s;
        s = '0;
        for (int j = 0; j < n; j++) s = s + RW'((int'(k[AW-1:0]) + j) % 1024 * 7 + 3);
        return s;
    endfunction

    // monitor: scoreboard pop plus per-cycle R1 and R6 port checks
    logic [NE-1:0] prev_g = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                mc = mc + 1;
                if (popped >= pushed) begin
                    mfl = mfl + 1;
                    $display("FAIL R5 unexpected result act=%h exp=none", res_data);
                end else begin
                    if (res_data !== exp_arr[popped % 256]) begin
                        mfl = mfl + 1;
                        $display("FAIL R5 result order/value act=%h exp=%h",
                                 res_data, exp_arr[popped % 256]);
                    end
                    popped = popped + 1;
                end
            end
            for (int i = 0; i < NE; i++) begin
                if (eng_grant[i]) begin
                    mc = mc + 1;
                    if (cyc % 8 != i) begin
                        mfl = mfl + 1;
                        $display("FAIL R1 grant to engine %0d in slot act=%0d exp=%0d", i, cyc % 8, i);
                    end
                end
            end
            mc = mc + 1;
            if (eng_rd_valid !== prev_g) begin
                mfl = mfl + 1;
                $display("FAIL R6 read return routing act=%b exp=%b", eng_rd_valid, prev_g);
            end
        end
        prev_g = rst_n ? eng_grant : '0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        ic = ic + 1;
        if (!ok) begin
            ifl = ifl + 1;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic send_lookup(input logic [KW-1:0] k, input int want_eng);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_key   = k;
        #1;
        if (want_eng >= 0)
            chk(eng_start == NE'(1 << want_eng), "R4", "round-robin pick",
                32'(eng_start), 32'(1 << want_eng));
        exp_arr[pushed % 256] = lookup_sum(k, rd_n);
        pushed = pushed + 1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] rexp, output int waited);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        waited = 0;
        forever begin
            #1;
            if (cpu_grant) break;
            @(negedge clk);
            waited = waited + 1;
        end
        chk(sram_en && (sram_we == we) && (sram_addr == a), "R7", "sram command on grant",
            {sram_en, sram_we, 20'd0, sram_addr}, {1'b1, we, 20'd0, a});
        if (we) chk(sram_wdata == d, "R7", "sram write data", sram_wdata, d);
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
        if (!we) begin
            @(negedge clk);
            chk(cpu_rvalid == 1'b1, "R6", "cpu read valid one cycle later", 32'(cpu_rvalid), 1);
            chk(cpu_rdata == rexp, "R7", "cpu read data", cpu_rdata, rexp);
        end
    endtask

    task automatic drain();
        while (popped != pushed) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        automatic logic [KW-1:0] keys_a [8] = '{3, 2, 1, 0, 7, 6, 5, 4};
        int w;
        rst_n = 1'b0; req_valid = 1'b0; req_key = '0;
        cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (4) @(posedge clk);
        #1;
        chk(req_ready && !res_valid && !sram_en, "R8", "outputs in reset",
            {req_ready, res_valid, sram_en}, 3'b100);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready && !res_valid && !sram_en && eng_grant == '0 && eng_start == '0 && !cpu_grant,
            "R8", "outputs after reset", {req_ready, res_valid, sram_en, cpu_grant}, 4'b1000);

        // R4/R5: eight keys to idle engines, finishing out of order
        rd_n = 2;
        for (int n = 0; n < 8; n++) send_lookup(keys_a[n], n);
        @(negedge clk);
        chk(req_ready == 1'b0, "R4", "ready low with all engines occupied", 32'(req_ready), 0);
        send_lookup(10, -1);
        send_lookup(21, -1);
        send_lookup(33, -1);
        send_lookup(40, -1);
        drain();
        chk(popped == 12, "R5", "all results returned", popped, 12);

        // R2/R7: control accesses while engines are idle
        cpu_op(1'b1, 10'd900, 32'hA5A5_1234, '0, w);
        chk(w == 0, "R2", "idle slot granted at once", w, 0);
        cpu_op(1'b0, 10'd900, '0, 32'hA5A5_1234, w);
        chk(w == 0, "R2", "idle slot granted at once (read)", w, 0);
        cpu_op(1'b0, 10'd5, '0, 32'(5 * 7 + 3), w);

        // R3: every slot busy, control must wait exactly eight cycles
        rd_n = 8;
        for (int n = 0; n < 8; n++) send_lookup(KW'(100 * (n + 1)), -1);
        repeat (20) @(negedge clk);
        cpu_op(1'b1, 10'd950, 32'h0BAD_F00D, '0, w);
        chk(w == 8, "R3", "forced grant after eight refused cycles", w, 8);
        drain();
        chk(popped == 20, "R5", "stress results returned", popped, 20);
        cpu_op(1'b0, 10'd950, '0, 32'h0BAD_F00D, w);

        $display("TB_RESULT checks=%0d failures=%0d", ic + mc, ifl + mfl);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog run did not finish act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", ic + mc + 1, ifl + mfl + 1);
        $finish;
    end

endmodule